// File: doc/BRIEF.md
# Sensor SPI Frame Transceiver with CRC

This block is an SPI master that carries one register access to an off-chip inertial sensor as two fixed 32-bit frames. A request names a read or a write, a 5-bit register number and a 16-bit value. The block builds a command frame from these, ends it with a checksum and shifts it out MSB-first while chip select is low. It then releases chip select and waits a timed gap. In a second chip-select frame it clocks the sensor's answer in.

Only the answer frame is used. The block checks the answer's checksum and decodes a 2-bit return status from its leading byte. It sign-extends the 16-bit payload and presents the payload with two error flags on a one-cycle completion pulse. The SPI clock divider and the gap length are derived from the system clock frequency through parameters. A scheduler upstream issues one request at a time over a ready/valid pair.

Top module: `sensor_frame_xcvr`

## Requirements
- R1: After reset, and whenever reset is asserted mid-transfer, `csN` is high, `sclk` is low, `reqReady` is high and `done` is low.
- R2: A request is taken on a clock edge where `reqValid` and `reqReady` are both high. After that edge `reqReady` stays low until the transaction has fully finished. A `reqValid` raised while busy starts no extra frame.
- R3: The command frame's byte 0 is `{write, addr[4:0], 2'b00}`, with write being 1 and read being 0. Bytes 1 and 2 carry the write data big-endian. Bits leave on `mosi` MSB-first in SPI mode 0: `sclk` idles low and the slave samples on the rising edge.
- R4: Byte 3 of the command frame is the bitwise inverse of a CRC-8 over bytes 0 to 2. The CRC uses polynomial 0x1D, is preset to 0xFF and is processed MSB-first.
- R5: Each transaction makes exactly two chip-select frames of 32 `sclk` periods each. Each `sclk` period is 2*HALF_DIV clocks. The second frame drives `mosi` low throughout.
- R6: `csN` stays high for GAP_CYCLES clocks between the two frames. After the second frame, GAP_CYCLES clocks pass before `reqReady` returns.
- R7: `rdData` is bytes 1 and 2 of the answer frame, big-endian and sign-extended to RES_W bits. Data sampled during the command frame is not used.
- R8: `crcErr` is set when byte 3 of the answer differs from the inverted CRC-8 (R4 rules) over its bytes 0 to 2.
- R9: `devErr` is set when bits 1:0 of the answer's byte 0 equal 2'b11.
- R10: `done` is high for exactly one clock, 1+128*HALF_DIV+GAP_CYCLES clocks after the accepting edge. The results change only with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request can be taken |
| reqWrite | input | 1 | 1 = register write, 0 = read |
| reqAddr | input | 5 | Sensor register number |
| reqWdata | input | 16 | Write value |
| sclk | output | 1 | SPI clock, idle low |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to sensor |
| miso | input | 1 | Serial data from sensor |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | RES_W | Sign-extended answer payload |
| crcErr | output | 1 | Answer checksum mismatch |
| devErr | output | 1 | Sensor return status signals an error |

## Verification
The completion pulse lands 1+128*HALF_DIV+GAP_CYCLES clocks after the accepting edge. The bench counts falling clock edges from the accept and requires the pulse on exactly that count. The pulse must be low one edge later, and `reqReady` must return exactly GAP_CYCLES edges after the pulse. The sensor model records every frame's shifted bits, its `sclk` rising-edge count and the chip-select gap in clock periods. Each of these is compared against values computed from the request, so frame layout and timing are checked at the pins rather than through internal state.

// File: rtl/sfx_pkg.sv
`timescale 1ns/1ps
package sfx_pkg;
  localparam int ADDR_W = 5;
  localparam int WORD_W = 16;
  localparam int FRAME_BITS = 32;
  localparam int BODY_BITS = 24;
  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_SEED = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_GAP1, S_RSP, S_GAP2} xfer_state_t;

  typedef struct packed {
    logic load;
    logic rxStart;
    logic sample;
    logic crcEn;
    logic shift;
    logic capture;
  } sfx_strobe_t;

  function automatic logic [7:0] crcStep(input logic [7:0] crc, input logic din);
    logic fb;
    fb = crc[7] ^ din;
    crcStep = {crc[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction

  function automatic logic [7:0] bodyCrc(input logic [BODY_BITS-1:0] body);
    logic [7:0] c;
    c = CRC_SEED;
    for (int i = BODY_BITS - 1; i >= 0; i--) c = crcStep(c, body[i]);
    bodyCrc = ~c;
  endfunction
endpackage

// File: rtl/sfx_ctrl.sv
`timescale 1ns/1ps
module sfx_ctrl
  import sfx_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int GAP_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        sclk,
  output logic        csN,
  output logic        done,
  output sfx_strobe_t st
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  xfer_state_t state;
  logic [DIV_W-1:0] divCnt;
  logic [4:0]       bitCnt;
  logic [GAP_W-1:0] gapCnt;
  logic sclkQ, csNQ, doneQ;

  logic divLast, bitLast, gapLast, inFrame;
  assign divLast = (divCnt == DIV_W'(HALF_DIV - 1));
  assign bitLast = (bitCnt == 5'd31);
  assign gapLast = (gapCnt == GAP_W'(GAP_CYCLES - 1));
  assign inFrame = (state == S_CMD) || (state == S_RSP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      gapCnt <= '0;
      sclkQ  <= 1'b0;
      csNQ   <= 1'b1;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        S_IDLE: if (reqValid) begin
          state  <= S_CMD;
          csNQ   <= 1'b0;
          divCnt <= '0;
          bitCnt <= '0;
          sclkQ  <= 1'b0;
        end
        S_CMD, S_RSP: begin
          if (divLast) begin
            divCnt <= '0;
            sclkQ  <= ~sclkQ;
            if (sclkQ) begin
              bitCnt <= bitCnt + 5'd1;
              if (bitLast) begin
                csNQ   <= 1'b1;
                gapCnt <= '0;
                state  <= (state == S_CMD) ? S_GAP1 : S_GAP2;
                doneQ  <= (state == S_RSP);
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        S_GAP1, S_GAP2: begin
          if (gapLast) begin
            gapCnt <= '0;
            if (state == S_GAP1) begin
              state  <= S_RSP;
              csNQ   <= 1'b0;
              divCnt <= '0;
              bitCnt <= '0;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st.load    = (state == S_IDLE) && reqValid;
    st.rxStart = (state == S_GAP1) && gapLast;
    st.sample  = (state == S_RSP) && divLast && !sclkQ;
    st.crcEn   = st.sample && (bitCnt < 5'd24);
    st.shift   = inFrame && divLast && sclkQ;
    st.capture = (state == S_RSP) && divLast && sclkQ && bitLast;
  end

  assign reqReady = (state == S_IDLE);
  assign sclk     = sclkQ;
  assign csN      = csNQ;
  assign done     = doneQ;

  a_r1_sclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && !csN));
  a_r5_sclk_rate: assert property (@(posedge clk) disable iff (!rstN)
    (sclk != $past(sclk)) |-> ($past(divCnt) == DIV_W'(HALF_DIV - 1)));
endmodule

// File: rtl/sfx_datapath.sv
`timescale 1ns/1ps
module sfx_datapath
  import sfx_pkg::*;
#(
  parameter int RES_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfx_strobe_t       st,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic              miso,
  output logic              mosi,
  output logic [RES_W-1:0]  rdData,
  output logic              crcErr,
  output logic              devErr
);
  logic [FRAME_BITS-1:0] txShift;
  logic [25:0]           rxShift;
  logic [7:0]            rxCrc;
  logic [BODY_BITS-1:0]  cmdBody;

  assign cmdBody = {reqWrite, reqAddr, 2'b00, reqWdata};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxCrc   <= CRC_SEED;
      rdData  <= '0;
      crcErr  <= 1'b0;
      devErr  <= 1'b0;
    end else begin
      if (st.load) txShift <= {cmdBody, bodyCrc(cmdBody)};
      else if (st.shift) txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      if (st.rxStart) rxCrc <= CRC_SEED;
      else if (st.crcEn) rxCrc <= crcStep(rxCrc, miso);
      if (st.sample) rxShift <= {rxShift[24:0], miso};
      if (st.capture) begin
        rdData <= {{(RES_W-WORD_W){rxShift[23]}}, rxShift[23:8]};
        crcErr <= (rxShift[7:0] != ~rxCrc);
        devErr <= (rxShift[25:24] == 2'b11);
      end
    end
  end

  assign mosi = txShift[FRAME_BITS-1];

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.capture |=> ($stable(rdData) && $stable(crcErr) && $stable(devErr)));
endmodule

// File: rtl/sensor_frame_xcvr.sv
`timescale 1ns/1ps
module sensor_frame_xcvr
  import sfx_pkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int SCLK_HZ = 4_000_000,
  parameter int GAP_US  = 10,
  parameter int RES_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [4:0]       reqAddr,
  input  logic [15:0]      reqWdata,
  output logic             sclk,
  output logic             csN,
  output logic             mosi,
  input  logic             miso,
  output logic             done,
  output logic [RES_W-1:0] rdData,
  output logic             crcErr,
  output logic             devErr
);
  localparam int HALF_RAW   = CLK_HZ / (2 * SCLK_HZ);
  localparam int HALF_DIV   = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int GAP_RAW    = (CLK_HZ / 1_000_000) * GAP_US;
  localparam int GAP_CYCLES = (GAP_RAW < 1) ? 1 : GAP_RAW;

  sfx_strobe_t st;

  sfx_ctrl #(.HALF_DIV(HALF_DIV), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .sclk(sclk), .csN(csN), .done(done), .st(st)
  );

  sfx_datapath #(.RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .miso(miso), .mosi(mosi), .rdData(rdData),
    .crcErr(crcErr), .devErr(devErr)
  );
endmodule

// File: tb/sim_sensor_frame_xcvr.sv
`timescale 1ns/1ps
module sim_sensor_frame_xcvr;
  localparam int PERIOD = 10;
  localparam int H = 2;
  localparam int G = 16;
  localparam int LAT = 1 + 128 * H + G;
  localparam int NV = 6;
  // {wr, addr, wdata, respHead, respData, corruptCrc}
  localparam logic [46:0] VEC [NV] = '{
    {1'b1, 5'h0D, 16'h0020, 8'h34, 16'h0020, 1'b0},
    {1'b0, 5'h10, 16'h0000, 8'h40, 16'h0051, 1'b0},
    {1'b0, 5'h01, 16'h0000, 8'h04, 16'h8001, 1'b0},
    {1'b0, 5'h02, 16'h0000, 8'h0B, 16'h1234, 1'b0},
    {1'b0, 5'h03, 16'h0000, 8'h0C, 16'hFFFF, 1'b1},
    {1'b1, 5'h1F, 16'hA5C3, 8'h7F, 16'h7FFF, 1'b1}
  };

  logic clk = 0, rstN = 0, reqValid = 0, reqWrite = 0, miso = 0;
  logic [4:0] reqAddr = 0;
  logic [15:0] reqWdata = 0;
  logic reqReady, sclk, csN, mosi, done, crcErr, devErr;
  logic [31:0] rdData;

  int total = 0, bad = 0;
  logic [31:0] respFrame = 0;
  int frameCnt = 0;
  logic [31:0] capRing [2];
  int riseRing [2];
  int gapRing [2];
  time lastRise = 0;

  always #(PERIOD/2) clk = ~clk;

  sensor_frame_xcvr #(.CLK_HZ(16_000_000), .SCLK_HZ(4_000_000), .GAP_US(1), .RES_W(32)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso), .done(done),
    .rdData(rdData), .crcErr(crcErr), .devErr(devErr)
  );

  function automatic logic [7:0] refCrc(input logic [23:0] b);
    logic [7:0] c = 8'hFF;
    for (int i = 23; i >= 0; i--) begin
      if (c[7] ^ b[i]) c = {c[6:0], 1'b0} ^ 8'h1D;
      else c = {c[6:0], 1'b0};
    end
    return ~c;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sensor model: mode 0 slave
  initial begin
    forever begin
      logic [31:0] cap;
      int rises, idx, slot;
      time tFall;
      @(negedge csN);
      tFall = $time;
      slot = frameCnt % 2;
      gapRing[slot] = int'((tFall - lastRise) / PERIOD);
      cap = 0; rises = 0; idx = 0;
      miso = respFrame[31];
      while (!csN) begin
        @(posedge sclk or posedge csN);
        if (csN) break;
        cap = {cap[30:0], mosi};
        rises++;
        @(negedge sclk or posedge csN);
        if (csN) break;
        idx++;
        if (idx < 32) miso = respFrame[31 - idx];
      end
      lastRise = $time;
      capRing[slot] = cap;
      riseRing[slot] = rises;
      frameCnt++;
    end
  end

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic runVec(input logic [46:0] v, input logic poke);
    logic wr; logic [4:0] a; logic [15:0] wd, rd; logic [7:0] hd; logic corrupt;
    logic [31:0] expCmd, expRd;
    int base, cnt, k;
    {wr, a, wd, hd, rd, corrupt} = v;
    expCmd = {wr, a, 2'b00, wd, refCrc({wr, a, 2'b00, wd})};
    respFrame = {hd, rd, refCrc({hd, rd}) ^ {7'b0, corrupt}};
    expRd = {{16{rd[15]}}, rd};
    base = frameCnt;
    @(negedge clk);
    chk(reqReady == 1'b1, "R2 ready before request", {31'b0, reqReady}, 1);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    chk(reqReady == 1'b0, "R2 ready drops after accept", {31'b0, reqReady}, 0);
    cnt = 1;
    while (!done && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 100) begin reqValid = 1; reqAddr = 5'h1F; reqWrite = 1; end
      if (poke && cnt == 110) reqValid = 0;
    end
    chk(cnt == LAT, "R10 done latency", cnt, LAT);
    chk(capRing[base % 2] == expCmd, "R3 R4 command frame", capRing[base % 2], expCmd);
    chk(riseRing[base % 2] == 32, "R5 command sclk count", riseRing[base % 2], 32);
    chk(riseRing[(base + 1) % 2] == 32, "R5 answer sclk count", riseRing[(base + 1) % 2], 32);
    chk(capRing[(base + 1) % 2] == 0, "R5 answer frame mosi low", capRing[(base + 1) % 2], 0);
    chk(gapRing[(base + 1) % 2] == G, "R6 gap between frames", gapRing[(base + 1) % 2], G);
    chk(rdData == expRd, "R7 payload", rdData, expRd);
    chk(crcErr == corrupt, "R8 crc flag", {31'b0, crcErr}, {31'b0, corrupt});
    chk(devErr == (hd[1:0] == 2'b11), "R9 status flag", {31'b0, devErr}, {31'b0, hd[1:0] == 2'b11});
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", {31'b0, done}, 0);
    k = 1;
    while (!reqReady && k < 5000) begin @(negedge clk); k++; end
    chk(k == G, "R6 gap before ready", k, G);
    chk(rdData == expRd, "R10 result held", rdData, expRd);
    chk(frameCnt == base + 2, "R2 no extra frame", frameCnt, base + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csN === 1'b1 && sclk === 1'b0, "R1 reset pins", {30'b0, csN, sclk}, 32'h2);
    chk(reqReady === 1'b1 && done === 1'b0, "R1 reset handshake", {30'b0, reqReady, done}, 32'h2);
    rstN = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NV; i++) runVec(VEC[i], 1'b0);
    // R2: valid during busy ignored
    runVec({1'b0, 5'h05, 16'h0000, 8'h00, 16'hC000, 1'b0}, 1'b1);
    repeat (5) @(negedge clk);
    chk(csN == 1'b1, "R2 busy request dropped", {31'b0, csN}, 1);
    // R1: reset mid-frame
    @(negedge clk);
    reqValid = 1; reqAddr = 5'h09; reqWrite = 0;
    @(negedge clk);
    reqValid = 0;
    repeat (20) @(negedge clk);
    rstN = 0;
    @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b0, "R1 mid-frame reset pins", {30'b0, csN, sclk}, 32'h2);
    chk(reqReady == 1'b1 && done == 1'b0, "R1 mid-frame reset handshake", {30'b0, reqReady, done}, 32'h2);
    rstN = 1;
    repeat (2) @(negedge clk);
    runVec(VEC[2], 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule